// File: doc/BRIEF.md
# EDID Block Checksum Validator

This block walks a display identification memory through a fixed read sequence and checks each 128-byte block it fetches. It does not drive the I2C bus. Instead it hands read requests to an external I2C bus master as a triple of device address, start offset and length. The master then returns the bytes one at a time on a byte-valid strobe, or signals a read error.

After a start pulse, the block first fetches the single extension-count byte. It then fetches the base block. If the count is nonzero, it also fetches one extension block, which lies directly after the base block in the memory.

For every block, the block keeps a running modulo-256 sum and judges the block when its last byte arrives. The sequence ends in one of three ways: a pass, a checksum error or a read failure. The outcome is held until the next start. The checksum byte of the last block read is kept on an output. When the sink has asked for an EDID-read test, a one-cycle write strobe is raised with that byte, so that the reply to the sink can be formed.

Top module: `edid_csum_chk`

## Requirements
- R1: After reset, every output is low, including `rq_valid_o`, all status flags, `csum_byte_o` and `csum_wr_o`.
- R2: Every read request carries device address 0x50. After a start pulse, the first request asks for offset 126 with length 1. A request stays valid, with offset and length stable, until the cycle in which `rq_ready_i` is high.
- R3: If the extension-count byte is zero, the block requests only the base block (offset 0, length 128). If the count is nonzero and the base block is good, it then requests offset 128 with length 128 and checks that block as well.
- R4: A block is good when the 8-bit sum of its 128 bytes, modulo 256, is zero. When every block fetched is good, the sequence ends with `done_o` and `pass_o` high.
- R5: A block whose sum is nonzero ends the sequence with `done_o` and `csum_err_o` high. No further read request follows.
- R6: Any nonzero extension count fetches exactly one extension block. `ext_warn_o` is high when the count is greater than 1, and low otherwise.
- R7: An `rx_err_i` pulse while bytes are awaited ends the sequence at once with `done_o` and `rd_err_o` high. `pass_o` and `csum_err_o` stay low.
- R8: The final status holds until the next start pulse, and exactly one of pass, checksum error or read failure is high with `done_o`. A start pulse while a sequence is running is ignored.
- R9: `csum_byte_o` shows byte 127 of the last block fully received, or 0 if no block has completed since start. On a passing end, `csum_wr_o` pulses for exactly one cycle, together with the rise of `done_o`, if `test_edid_i` is high. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new read-and-check sequence |
| test_edid_i | input | 1 | Sink test request asks for the EDID checksum reply |
| rq_valid_o | output | 1 | Read request pending to the bus master |
| rq_ready_i | input | 1 | Bus master accepts the request |
| rq_dev_o | output | 7 | I2C device address of the request |
| rq_off_o | output | 8 | Start offset of the request |
| rq_len_o | output | 8 | Number of bytes requested |
| rx_valid_i | input | 1 | A returned byte is present |
| rx_data_i | input | 8 | Returned byte |
| rx_err_i | input | 1 | Bus master reports a failed read |
| done_o | output | 1 | Sequence finished, held until next start |
| pass_o | output | 1 | All fetched blocks were good |
| csum_err_o | output | 1 | A block failed its checksum |
| rd_err_o | output | 1 | The bus master reported a read failure |
| ext_warn_o | output | 1 | Extension count was greater than one |
| csum_byte_o | output | 8 | Checksum byte of the last block received |
| csum_wr_o | output | 1 | One-cycle strobe to write the checksum reply |

## Verification
Extension counts of 0, 1 and larger values are tried. These show whether the second block is fetched, and whether the warning is raised without fetching more than one extension. Blocks are built with a correct checksum byte, or with the checksum byte off by one, in either the base or the extension block. This tells a per-block sum apart from a sum carried across blocks, and shows that the sequence stops after the first bad block. Read errors are injected during the count read and inside each block, and random bus stalls and byte gaps check that progress follows only the handshakes. A start pulse in mid-sequence and runs with the test-request bit both set and clear check that the result is held and that the strobe is gated.

// File: rtl/edid_chk_pkg.sv
package edid_chk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RECV = 2'd2,
    ST_END  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_EXTCNT = 2'd0,
    PH_BASE   = 2'd1,
    PH_EXTN   = 2'd2
  } phase_e;

  // running modulo-256 accumulation of one byte
  function automatic logic [7:0] sum8(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // a block is intact when its total wraps to zero
  function automatic logic sum_ok(input logic [7:0] total);
    return total == 8'd0;
  endfunction

endpackage

// File: rtl/edid_byte_acc.sv
module edid_byte_acc
  import edid_chk_pkg::*;
#(
  parameter int BLK_LEN = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] sum_nx,
  output logic       at_last
);
  localparam int IDXW = $clog2(BLK_LEN);

  logic [7:0]      sum_q;
  logic [IDXW-1:0] idx_q;

  assign sum_nx  = sum8(sum_q, din);
  assign at_last = (idx_q == IDXW'(BLK_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (clr) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (en) begin
      sum_q <= sum_nx;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/edid_rd_req.sv
module edid_rd_req #(
  parameter int          ADDR_W   = 7,
  parameter int          OFF_W    = 8,
  parameter int          LEN_W    = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [OFF_W-1:0]  off,
  output logic [LEN_W-1:0]  len,
  output logic              fire
);
  assign addr = ADDR_W'(DEV_ADDR);
  assign fire = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      off   <= '0;
      len   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      off   <= ld_off;
      len   <= ld_len;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edid_seq_ctrl.sv
module edid_seq_ctrl
  import edid_chk_pkg::*;
#(
  parameter int BLK_LEN = 128,
  parameter int EXT_OFF = 126,
  parameter int OFF_W   = 8,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             test_edid,
  input  logic             rq_fire,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_err,
  input  logic [7:0]       sum_nx,
  input  logic             at_last,
  output logic             issue,
  output logic [OFF_W-1:0] issue_off,
  output logic [LEN_W-1:0] issue_len,
  output logic             acc_en,
  output logic             blk_end,
  output logic             blk_good,
  output logic             recv,
  output logic             done,
  output logic             pass,
  output logic             csum_err,
  output logic             rd_err,
  output logic             ext_warn,
  output logic [7:0]       csum_byte,
  output logic             csum_wr
);
  seq_st_e    st_q;
  phase_e     ph_q;
  logic [7:0] ext_q;
  logic       go, rx_take, need_ext, ext_next;

  assign recv     = (st_q == ST_RECV);
  assign go       = start && (st_q == ST_IDLE || st_q == ST_END);
  assign rx_take  = recv && rx_valid && !rx_err;
  assign acc_en   = rx_take && (ph_q != PH_EXTCNT);
  assign blk_end  = acc_en && at_last;
  assign blk_good = sum_ok(sum_nx);
  assign need_ext = (ext_q != 8'd0);
  assign ext_next = blk_end && blk_good && (ph_q == PH_BASE) && need_ext;

  always_comb begin
    issue     = 1'b0;
    issue_off = '0;
    issue_len = '0;
    if (go) begin
      issue     = 1'b1;
      issue_off = OFF_W'(EXT_OFF);
      issue_len = LEN_W'(1);
    end else if (rx_take && ph_q == PH_EXTCNT) begin
      issue     = 1'b1;
      issue_off = '0;
      issue_len = LEN_W'(BLK_LEN);
    end else if (ext_next) begin
      issue     = 1'b1;
      issue_off = OFF_W'(BLK_LEN);
      issue_len = LEN_W'(BLK_LEN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_EXTCNT;
      ext_q     <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      csum_err  <= 1'b0;
      rd_err    <= 1'b0;
      ext_warn  <= 1'b0;
      csum_byte <= '0;
      csum_wr   <= 1'b0;
    end else begin
      csum_wr <= 1'b0;
      case (st_q)
        ST_IDLE, ST_END: begin
          if (go) begin
            st_q      <= ST_REQ;
            ph_q      <= PH_EXTCNT;
            ext_q     <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            csum_err  <= 1'b0;
            rd_err    <= 1'b0;
            ext_warn  <= 1'b0;
            csum_byte <= '0;
          end
        end
        ST_REQ: begin
          if (rq_fire) st_q <= ST_RECV;
        end
        ST_RECV: begin
          if (rx_err) begin
            st_q   <= ST_END;
            done   <= 1'b1;
            rd_err <= 1'b1;
          end else if (rx_take) begin
            if (ph_q == PH_EXTCNT) begin
              ext_q    <= rx_data;
              ext_warn <= (rx_data > 8'd1);
              ph_q     <= PH_BASE;
              st_q     <= ST_REQ;
            end else if (at_last) begin
              csum_byte <= rx_data;
              if (!blk_good) begin
                st_q     <= ST_END;
                done     <= 1'b1;
                csum_err <= 1'b1;
              end else if (ext_next) begin
                ph_q <= PH_EXTN;
                st_q <= ST_REQ;
              end else begin
                st_q    <= ST_END;
                done    <= 1'b1;
                pass    <= 1'b1;
                csum_wr <= test_edid;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edid_csum_chk.sv
module edid_csum_chk #(
  parameter int         BLK_LEN  = 128,
  parameter int         EXT_OFF  = 126,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  localparam int        OFF_W    = $clog2(2 * BLK_LEN),
  localparam int        LEN_W    = $clog2(BLK_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             test_edid_i,
  output logic             rq_valid_o,
  input  logic             rq_ready_i,
  output logic [6:0]       rq_dev_o,
  output logic [OFF_W-1:0] rq_off_o,
  output logic [LEN_W-1:0] rq_len_o,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_err_i,
  output logic             done_o,
  output logic             pass_o,
  output logic             csum_err_o,
  output logic             rd_err_o,
  output logic             ext_warn_o,
  output logic [7:0]       csum_byte_o,
  output logic             csum_wr_o
);
  logic             issue_w, fire_w, acc_en_w;
  logic [OFF_W-1:0] issue_off_w;
  logic [LEN_W-1:0] issue_len_w;
  logic [7:0]       sum_nx_w;
  logic             at_last_w;
  logic             blk_end_w, blk_good_w, recv_w;

  edid_rd_req #(
    .ADDR_W(7), .OFF_W(OFF_W), .LEN_W(LEN_W), .DEV_ADDR(DEV_ADDR)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .load(issue_w), .ld_off(issue_off_w),
    .ld_len(issue_len_w), .ready(rq_ready_i), .valid(rq_valid_o),
    .addr(rq_dev_o), .off(rq_off_o), .len(rq_len_o), .fire(fire_w)
  );

  edid_byte_acc #(.BLK_LEN(BLK_LEN)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(issue_w), .en(acc_en_w),
    .din(rx_data_i), .sum_nx(sum_nx_w), .at_last(at_last_w)
  );

  edid_seq_ctrl #(
    .BLK_LEN(BLK_LEN), .EXT_OFF(EXT_OFF), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .test_edid(test_edid_i),
    .rq_fire(fire_w), .rx_valid(rx_valid_i), .rx_data(rx_data_i),
    .rx_err(rx_err_i), .sum_nx(sum_nx_w), .at_last(at_last_w),
    .issue(issue_w), .issue_off(issue_off_w), .issue_len(issue_len_w),
    .acc_en(acc_en_w), .blk_end(blk_end_w), .blk_good(blk_good_w),
    .recv(recv_w), .done(done_o), .pass(pass_o), .csum_err(csum_err_o),
    .rd_err(rd_err_o), .ext_warn(ext_warn_o), .csum_byte(csum_byte_o),
    .csum_wr(csum_wr_o)
  );
endmodule

// File: rtl/edid_chk_sva.sv
module edid_chk_sva #(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rq_valid_o,
  input logic       rq_ready_i,
  input logic [6:0] rq_dev_o,
  input logic [7:0] rq_off_o,
  input logic [7:0] rq_len_o,
  input logic       rx_err_i,
  input logic       done_o,
  input logic       pass_o,
  input logic       csum_err_o,
  input logic       rd_err_o,
  input logic [7:0] csum_byte_o,
  input logic       csum_wr_o,
  input logic       blk_end_w,
  input logic       blk_good_w,
  input logic       recv_w
);
  p_req_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o |-> rq_dev_o == DEV_ADDR);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid_o && !rq_ready_i |=> rq_valid_o && $stable(rq_off_o) && $stable(rq_len_o));

  p_bad_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end_w && !blk_good_w |=> done_o && csum_err_o && !pass_o);

  p_no_req_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rq_valid_o);

  p_rd_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recv_w && rx_err_i |=> done_o && rd_err_o && !pass_o && !csum_err_o);

  p_one_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot({pass_o, csum_err_o, rd_err_o}));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable({pass_o, csum_err_o, rd_err_o, csum_byte_o}));

  p_wr_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csum_wr_o |-> done_o && pass_o);

  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csum_wr_o |=> !csum_wr_o);
endmodule

bind edid_csum_chk edid_chk_sva #(.DEV_ADDR(DEV_ADDR)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rq_valid_o(rq_valid_o),
  .rq_ready_i(rq_ready_i), .rq_dev_o(rq_dev_o), .rq_off_o(rq_off_o),
  .rq_len_o(rq_len_o), .rx_err_i(rx_err_i), .done_o(done_o),
  .pass_o(pass_o), .csum_err_o(csum_err_o), .rd_err_o(rd_err_o),
  .csum_byte_o(csum_byte_o), .csum_wr_o(csum_wr_o),
  .blk_end_w(blk_end_w), .blk_good_w(blk_good_w), .recv_w(recv_w)
);

// File: tb/test_edid_csum_chk.sv
module test_edid_csum_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, test_edid_i = 1'b0;
  logic       rq_ready_i = 1'b0, rx_valid_i = 1'b0, rx_err_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rq_valid_o, done_o, pass_o, csum_err_o, rd_err_o, ext_warn_o, csum_wr_o;
  logic [6:0] rq_dev_o;
  logic [7:0] rq_off_o, rq_len_o, csum_byte_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] blk [2][128];

  always #4 clk = ~clk;

  edid_csum_chk i_edid_csum_chk (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] sum_prefix(input int b, input int upto);
    logic [7:0] s = 8'd0;
    for (int i = 0; i < upto; i++) s = s + blk[b][i];
    return s;
  endfunction

  task automatic serve_req(input int eoff, input int elen);
    int waitc = 0;
    while (!rq_valid_o && waitc < 60) begin
      @(negedge clk);
      waitc++;
    end
    chk(rq_valid_o, "R2", "request issued", int'(rq_valid_o), 1);
    chk(rq_dev_o == 7'h50, "R2", "device address", int'(rq_dev_o), 'h50);
    chk(int'(rq_off_o) == eoff, "R3", "request offset", int'(rq_off_o), eoff);
    chk(int'(rq_len_o) == elen, "R3", "request length", int'(rq_len_o), elen);
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      if (!rq_valid_o || int'(rq_off_o) != eoff)
        chk(0, "R2", "request held during stall", int'(rq_off_o), eoff);
    end
    rq_ready_i = 1'b1;
    @(negedge clk);
    rq_ready_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic send_err();
    rx_err_i = 1'b1;
    @(negedge clk);
    rx_err_i = 1'b0;
  endtask

  // err_at: -1 none, 0 during count read, 1+i base byte i, 129+i extension byte i
  task automatic run(input int ext, input bit bad0, input bit bad1,
                     input int err_at, input bit tbit, input bit mid_start);
    int   res = 0;          // 0 pass, 1 csum error, 2 read error
    logic [7:0] exp_cb = 8'd0;
    bit   stop = 0;
    int   nblk;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 127; i++) blk[b][i] = 8'($urandom);
      if (b == 0) blk[0][126] = 8'(ext);
      blk[b][127] = 8'(-sum_prefix(b, 127)) + ((b == 0 ? bad0 : bad1) ? 8'd1 : 8'd0);
    end
    test_edid_i = tbit;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    serve_req(126, 1);
    if (err_at == 0) begin
      send_err();
      res = 2; stop = 1;
    end else send_byte(8'(ext));
    nblk = (ext != 0) ? 2 : 1;
    for (int b = 0; b < nblk && !stop; b++) begin
      serve_req(b * 128, 128);
      for (int i = 0; i < 128 && !stop; i++) begin
        if (err_at == 1 + b * 128 + i) begin
          send_err();
          res = 2; stop = 1;
        end else begin
          if (mid_start && b == 0 && i == 50) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
          end
          send_byte(blk[b][i]);
        end
      end
      if (!stop) begin
        exp_cb = blk[b][127];
        if (sum_prefix(b, 128) != 8'd0) begin
          res = 1; stop = 1;
        end
      end
    end
    chk(done_o == 1'b1, "R8", "done at end", int'(done_o), 1);
    chk(pass_o == (res == 0), "R4", "pass flag", int'(pass_o), int'(res == 0));
    chk(csum_err_o == (res == 1), "R5", "checksum error flag", int'(csum_err_o), int'(res == 1));
    chk(rd_err_o == (res == 2), "R7", "read error flag", int'(rd_err_o), int'(res == 2));
    if (err_at != 0)
      chk(ext_warn_o == (ext > 1), "R6", "extension warning", int'(ext_warn_o), int'(ext > 1));
    chk(csum_byte_o == exp_cb, "R9", "checksum byte", int'(csum_byte_o), int'(exp_cb));
    chk(csum_wr_o == (res == 0 && tbit), "R9", "checksum write strobe",
        int'(csum_wr_o), int'(res == 0 && tbit));
    @(negedge clk);
    chk(csum_wr_o == 1'b0, "R9", "strobe one cycle", int'(csum_wr_o), 0);
    repeat (8) begin
      @(negedge clk);
      if (rq_valid_o) chk(0, "R5", "no request after end", 1, 0);
    end
    chk(done_o && pass_o == (res == 0) && rd_err_o == (res == 2), "R8", "status held",
        int'({done_o, pass_o, csum_err_o, rd_err_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rq_valid_o && !done_o && !pass_o && !csum_err_o && !rd_err_o && !ext_warn_o
        && csum_byte_o == 0 && !csum_wr_o, "R1", "reset state",
        int'({rq_valid_o, done_o, pass_o, csum_err_o, rd_err_o, ext_warn_o, csum_wr_o}), 0);
    run(0, 0, 0, -1, 1, 0);   // R3 no extension, R4 pass
    run(1, 0, 0, -1, 1, 0);   // R3 one extension
    run(3, 0, 0, -1, 0, 0);   // R6 warn, R9 strobe gated off
    run(1, 1, 0, -1, 1, 0);   // R5 base bad, extension not read
    run(1, 0, 1, -1, 1, 0);   // R5 extension bad
    run(0, 1, 0, -1, 1, 0);   // R5 base bad, no extension
    run(2, 0, 0, 0, 1, 0);    // R7 error on count read
    run(1, 0, 0, 60, 1, 0);   // R7 error inside base
    run(1, 0, 0, 200, 1, 0);  // R7 error inside extension
    run(1, 0, 0, -1, 1, 1);   // R8 start while busy ignored
    for (int k = 0; k < 12; k++) begin
      int e   = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 255));
      bit b0  = ($urandom_range(0, 4) == 0);
      bit b1  = ($urandom_range(0, 4) == 0);
      int ea  = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 250)) : -1;
      run(e, b0, b1, ea, 1'($urandom), 0);
    end
    summary();
  end
endmodule